// File: doc/BRIEF.md
# Interleaved I/Q Bus Receiver

This block sits on the receiving side of a dual-channel converter whose two 12-bit channels share one output bus. It runs on the converter's own clock. In paired mode the source drives the in-phase word while the clock is high and the quadrature word while it is low. The block takes the bus on both clock edges and rebuilds each I/Q pair from one sampling instant. The two channels differ in latency by half a cycle. The Q word seen on the falling edge that follows a rising-edge I word therefore comes from the same sampling instant, and the two are joined.

Two single-channel modes let the source hold its channel select high or low, so that every word belongs to one channel. A word is tagged with its kind and presented with a one-cycle valid strobe in the rising-edge domain. While the source bus output enable is high (bus floating), nothing captured is marked valid. For a parameterised number of rising edges after the bus comes back, output also stays silent so that words still settling in the converter pipeline are dropped. The source cannot be stalled, so the output has no ready input: the consumer must take each strobe in the cycle it appears. Data fields hold their last value between strobes.

Top module: `iq_bus_rx`

## Requirements
- R1: With `mode`=0 (paired), the word on `bus_d` at rising edge t goes to `out_i` and the word at the next falling edge goes to `out_q`, bit for bit (bit 11 most significant). They appear together with `out_valid`=1 and `out_kind`=0 after rising edge t+1.
- R2: With `mode`=1 (I only), each rising-edge word appears on `out_i` one rising edge later with `out_q`=0 and `out_kind`=1. The enable level at the falling edge has no effect.
- R3: With `mode`=2 (Q only), the word taken at the falling edge after rising edge t appears on `out_q` after rising edge t+1, with `out_i`=0 and `out_kind`=2.
- R4: `mode`=3 produces no valid strobe.
- R5: A word is never marked valid if `bus_oe_n` was high at its rising edge, or, in modes 0 and 2, at the falling edge that follows.
- R6: Each rising edge that sees `bus_oe_n` high, and likewise reset, starts a hold-off. The next HOLD_CYCLES rising edges with `bus_oe_n` low yield no valid output (default 8).
- R7: While `out_valid` is 0, `out_i`, `out_q` and `out_kind` keep their previous values.
- R8: During reset, `out_valid` is 0 and `out_i`, `out_q` and `out_kind` are all 0.
- R9: `mode` is sampled at the rising edge of each word, so a mode change takes effect from the next word with no lost or merged words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; rising edge carries I, falling edge carries Q |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 paired, 1 I only, 2 Q only, 3 off |
| bus_oe_n | input | 1 | Source bus output enable, high while the bus floats |
| bus_d | input | 12 | Shared converter data bus |
| out_valid | output | 1 | One-cycle strobe for a new word or pair |
| out_i | output | 12 | In-phase word |
| out_q | output | 12 | Quadrature word |
| out_kind | output | 2 | Kind of the presented word, same coding as `mode` |

## Verification
Two functions can fall in the same cycle. The first case is a disable seen only at the falling edge of a cycle whose rising edge captured a good I word. The second is a hold-off count running out on the same edge where the mode changes. The bench drives the enable high for half a cycle only, and switches mode on the edges at which the hold-off ends. A behavioural model then judges, on every clock, whether that exact pair is dropped or kept and which kind it carries.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;
  typedef enum logic [1:0] {
    MODE_PAIR = 2'd0,
    MODE_I    = 2'd1,
    MODE_Q    = 2'd2,
    MODE_OFF  = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/iq_edge_capture.sv
// Captures bus word and enable state on one clock edge, chosen by parameter.
module iq_edge_capture #(
  parameter int W       = 12,
  parameter bit ON_FALL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_d,
  input  logic         bus_oe_n,
  output logic [W-1:0] word,
  output logic         driven
);
  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word   <= '0;
          driven <= 1'b0;
        end else begin
          word   <= bus_d;
          driven <= ~bus_oe_n;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word   <= '0;
          driven <= 1'b0;
        end else begin
          word   <= bus_d;
          driven <= ~bus_oe_n;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/iq_holdoff.sv
// Counts rising edges after the bus returns; open only once the count is spent.
module iq_holdoff #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_oe_n,
  output logic open_now
);
  localparam int CW = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= RELOAD;
    else if (bus_oe_n)     cnt <= RELOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign open_now = (cnt == '0);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_n |=> (cnt == RELOAD));

  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/iq_pair_merge.sv
// Joins the rising-edge word with the following falling-edge word.
module iq_pair_merge
  import iq_rx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_word,
  input  logic         rise_ok,
  input  rx_mode_e     rise_mode,
  input  logic [W-1:0] fall_word,
  input  logic         fall_ok,
  output logic         out_valid,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic [1:0]   out_kind
);
  logic fire;

  always_comb begin
    fire = rise_ok && (rise_mode != MODE_OFF) &&
           ((rise_mode == MODE_I) || fall_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_kind  <= 2'd0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_i    <= (rise_mode == MODE_Q) ? '0 : rise_word;
        out_q    <= (rise_mode == MODE_I) ? '0 : fall_word;
        out_kind <= rise_mode;
      end
    end
  end

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q) && $stable(out_kind)));

  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind != MODE_OFF));

  p_q_only_zero_i_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == MODE_Q) |-> (out_i == '0));

  p_i_only_zero_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == MODE_I) |-> (out_q == '0));
endmodule

// File: rtl/iq_bus_rx.sv
module iq_bus_rx
  import iq_rx_pkg::*;
#(
  parameter int W           = 12,
  parameter int HOLD_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         bus_oe_n,
  input  logic [W-1:0] bus_d,
  output logic         out_valid,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic [1:0]   out_kind
);
  logic [W-1:0] rise_word, fall_word;
  logic         rise_driven, fall_driven;
  logic         hold_open;
  logic         rise_open_r;
  rx_mode_e     rise_mode_r;

  iq_edge_capture #(.W(W), .ON_FALL(1'b0)) u_rise (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .bus_oe_n(bus_oe_n),
    .word(rise_word), .driven(rise_driven)
  );

  iq_edge_capture #(.W(W), .ON_FALL(1'b1)) u_fall (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .bus_oe_n(bus_oe_n),
    .word(fall_word), .driven(fall_driven)
  );

  iq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .bus_oe_n(bus_oe_n), .open_now(hold_open)
  );

  // side data travelling with the rising-edge word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_open_r <= 1'b0;
      rise_mode_r <= MODE_OFF;
    end else begin
      rise_open_r <= hold_open;
      rise_mode_r <= rx_mode_e'(mode);
    end
  end

  iq_pair_merge #(.W(W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .rise_word(rise_word), .rise_ok(rise_driven && rise_open_r),
    .rise_mode(rise_mode_r),
    .fall_word(fall_word), .fall_ok(fall_driven),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_kind(out_kind)
  );

  p_disabled_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!bus_oe_n, 2));

  p_holdoff_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(hold_open, 2));

  p_mode_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind == $past(mode, 2)));
endmodule

// File: tb/iq_bus_rx_test.sv
`timescale 1ns/1ps
module iq_bus_rx_test;
  localparam int W    = 12;
  localparam int HOLD = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         bus_oe_n = 1'b1;
  logic [W-1:0] bus_d = '0;
  logic         out_valid;
  logic [W-1:0] out_i, out_q;
  logic [1:0]   out_kind;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iq_bus_rx #(.W(W), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_oe_n(bus_oe_n), .bus_d(bus_d),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_kind(out_kind)
  );

  // reference model state
  int           hc;
  bit           pv;
  logic [W-1:0] pi, pq;
  logic [1:0]   pk;
  bit           ev;
  logic [W-1:0] ei, eq;
  logic [1:0]   ek;

  task automatic compare(string tag);
    checks++;
    if (out_valid !== ev || out_i !== ei || out_q !== eq || out_kind !== ek) begin
      bad++;
      $display("FAIL %s t=%0t actual v=%0b i=%h q=%h k=%0d expected v=%0b i=%h q=%h k=%0d",
               tag, $time, out_valid, out_i, out_q, out_kind, ev, ei, eq, ek);
    end
  endtask

  // entered 5 ns before a rising edge
  task automatic cyc(input logic [W-1:0] rv, input bit ro,
                     input logic [W-1:0] fv, input bit fo,
                     input logic [1:0] md, input string tag);
    bit elig;
    bus_d = rv; bus_oe_n = ro; mode = md;
    @(posedge clk);
    ev = pv;
    if (pv) begin ei = pi; eq = pq; ek = pk; end
    elig = !ro && (hc == 0) && (md != 2'd3) && ((md == 2'd1) || !fo);
    hc = ro ? HOLD : ((hc > 0) ? hc - 1 : 0);
    pv = elig;
    pi = (md == 2'd2) ? '0 : rv;
    pq = (md == 2'd1) ? '0 : fv;
    pk = md;
    #3 compare(tag);
    #2 bus_d = fv; bus_oe_n = fo;
    @(negedge clk);
    #5;
  endtask

  initial begin
    hc = HOLD; pv = 0; pi = '0; pq = '0; pk = '0;
    ev = 0; ei = '0; eq = '0; ek = '0;
    @(posedge clk);
    #3 compare("R8");
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R6: hold-off after reset, then first valid pair
    for (int k = 0; k < HOLD + 2; k++)
      cyc(12'h100 + W'(k), 0, 12'h200 + W'(k), 0, 2'd0, "R6");
    // R1: paired mode, varied patterns incl. MSB
    for (int k = 0; k < 16; k++)
      cyc(W'(k * 273) ^ 12'h800, 0, W'(k * 91) | ((k % 2) ? 12'hF00 : 12'h000),
          0, 2'd0, "R1");
    cyc(12'hFFF, 0, 12'h000, 0, 2'd0, "R1");
    cyc(12'h000, 0, 12'hFFF, 0, 2'd0, "R1");
    // R2: I only, falling-edge enable ignored
    for (int k = 0; k < 10; k++)
      cyc(12'h3C0 + W'(k), 0, 12'hABC, bit'(k % 2), 2'd1, "R2");
    // R3: Q only
    for (int k = 0; k < 10; k++)
      cyc(12'h555, 0, 12'h0A0 + W'(k * 5), 0, 2'd2, "R3");
    // R4: off mode, then R7 data held
    for (int k = 0; k < 6; k++)
      cyc(12'h111, 0, 12'h222, 0, 2'd3, "R4");
    cyc(12'h333, 0, 12'h444, 0, 2'd3, "R7");
    // R5: disable only at the falling half in paired and Q modes
    for (int k = 0; k < 8; k++)
      cyc(12'h600 + W'(k), 0, 12'h700 + W'(k), bit'(k % 3 == 1), (k < 4) ? 2'd0 : 2'd2, "R5");
    // R5/R6: disable at rising edge reloads hold-off
    cyc(12'h7AA, 1, 12'h7BB, 1, 2'd0, "R5");
    cyc(12'h7CC, 1, 12'h7DD, 0, 2'd0, "R5");
    for (int k = 0; k < HOLD + 3; k++)
      cyc(12'h900 + W'(k), 0, 12'h980 + W'(k), 0, (k == HOLD) ? 2'd1 : 2'd0, "R6");
    // R9: mode changes every word
    for (int k = 0; k < 9; k++)
      cyc(12'hC00 + W'(k), 0, 12'hD00 + W'(k), 0, 2'(k % 3), "R9");
    cyc(12'h000, 0, 12'h000, 0, 2'd3, "R7");
    cyc(12'h000, 0, 12'h000, 0, 2'd3, "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule